// File: doc/BRIEF.md
# POLYVAL Hash Multiply-Accumulate Engine

This block computes the POLYVAL universal hash over a stream of 128-bit blocks under a 128-bit hash key. Software or an upstream formatter first writes the key through a one-cycle key-load strobe. It then presents the blocks one per valid cycle, and flags the final block of each message. For a GCM-SIV style tag, that sequence is the associated data, then the message, then a block carrying both byte lengths. For every accepted block the engine folds the block into a 128-bit running value. It XORs the block with that value and multiplies the sum by the key in the POLYVAL field.

Each update completes in one clock. A carry-less product is built from four 64x64 partial products. It is then reduced by two folding multiplications by a constant, each paired with a half swap of the low accumulator, instead of a bit-by-bit polynomial division. The running value is always visible on the output. A one-cycle done strobe marks the cycle in which the hash of a finished message is present. The next message starts from zero without any extra command.

Top module: `polyval_mac`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hashOut` is all zeros and `hashDone` is low.
- R2: A cycle with `keyValid` high stores `keyIn` as the hash key. From the following cycle on, `hashOut` reads zero and `hashDone` is low.
- R3: Each accepted block X updates the running value T to dot(X xor T, H), where dot(a,b) = a·b·x^-128 mod x^128+x^127+x^126+x^121+1. Bit i of a 128-bit word is the coefficient of x^i, so a block given as a byte string maps to the word by treating byte 0 as the least significant byte. The new T appears on `hashOut` in the cycle after the accepting clock edge.
- R4: The first block after reset, after a key load, or after a block flagged last is combined with a zero running value, not with the previous hash.
- R5: `hashDone` is high for exactly the one cycle after the edge that accepts a block with `blkLast` high. It stays low after blocks without `blkLast`. `hashOut` holds that message's hash until the next accepted block or key load.
- R6: When `keyValid` and `blkValid` are high in the same cycle, the key load wins and the block is dropped. `hashOut` reads zero afterwards and no done strobe follows.
- R7: In cycles with neither `keyValid` nor `blkValid` high, `hashOut` does not change and `hashDone` falls low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| keyValid | input | 1 | Load `keyIn` as the hash key and clear the running value |
| keyIn | input | 128 | Hash key H |
| blkValid | input | 1 | `blkData` holds a block to absorb this cycle |
| blkLast | input | 1 | Marks the block as the final one of its message |
| blkData | input | 128 | Input block X |
| hashOut | output | 128 | Current running hash value |
| hashDone | output | 1 | One-cycle strobe: `hashOut` holds a finished message hash |

## Verification
On every cycle the checker confirms several control properties. The done strobe appears after an accepted last block and only then. A key load, including one that collides with a block, leaves a zero hash and no strobe. Idle cycles leave the hash unchanged. It also checks the reset values. The field arithmetic itself can only be shown by the bench scenarios. These compare the hash against a published POLYVAL vector and against a bit-serial multiply for random keys and blocks over several message lengths. The same scenarios show that a fresh message restarts from zero.

// File: rtl/polyval_pkg.sv
package polyval_pkg;
  parameter int unsigned HALF_W = 64;
  localparam int unsigned BLK_W = 2 * HALF_W;
  localparam int unsigned PROD_W = 2 * BLK_W;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [BLK_W-1:0]  blk_t;

  // High qword of the folded reduction constant for x^128+x^127+x^126+x^121+1
  localparam half_t FOLD_HI = 64'hC200000000000000;

  typedef struct packed {
    logic loadKey;  // capture key, clear accumulator
    logic absorb;   // fold one block into accumulator
    logic useZero;  // start of message: ignore previous accumulator
  } ctrl_strobes_t;

  // Carry-less 64x64 -> 128 product
  function automatic blk_t clmulHalf(input half_t a, input half_t b);
    blk_t acc;
    acc = '0;
    for (int i = 0; i < HALF_W; i++) begin
      if (b[i]) acc = acc ^ (blk_t'(a) << i);
    end
    return acc;
  endfunction
endpackage

// File: rtl/polyval_ctrl.sv
module polyval_ctrl
  import polyval_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          keyValid,
  input  logic          blkValid,
  input  logic          blkLast,
  output ctrl_strobes_t strobes,
  output logic          doneReg
);
  logic freshMsg;

  always_comb begin
    strobes.loadKey = keyValid;
    strobes.absorb  = blkValid & ~keyValid;
    strobes.useZero = freshMsg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freshMsg <= 1'b1;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= strobes.absorb & blkLast;
      if (strobes.loadKey)     freshMsg <= 1'b1;
      else if (strobes.absorb) freshMsg <= blkLast;
    end
  end
endmodule

// File: rtl/polyval_dp.sv
module polyval_dp
  import polyval_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strobes_t strobes,
  input  blk_t          keyIn,
  input  blk_t          blkData,
  output blk_t          accOut
);
  blk_t keyReg, accReg;
  blk_t opA, midTerm, lowPart, highPart, fold1, fold2, product;

  assign opA = blkData ^ (strobes.useZero ? '0 : accReg);

  // Schoolbook product from four partial products
  always_comb begin
    midTerm  = clmulHalf(opA[HALF_W-1:0], keyReg[BLK_W-1:HALF_W])
             ^ clmulHalf(opA[BLK_W-1:HALF_W], keyReg[HALF_W-1:0]);
    lowPart  = clmulHalf(opA[HALF_W-1:0], keyReg[HALF_W-1:0])
             ^ {midTerm[HALF_W-1:0], {HALF_W{1'b0}}};
    highPart = clmulHalf(opA[BLK_W-1:HALF_W], keyReg[BLK_W-1:HALF_W])
             ^ {{HALF_W{1'b0}}, midTerm[BLK_W-1:HALF_W]};
  end

  // Two folds: multiply low qword by constant, swap halves, combine
  always_comb begin
    fold1   = clmulHalf(lowPart[HALF_W-1:0], FOLD_HI)
            ^ {lowPart[HALF_W-1:0], lowPart[BLK_W-1:HALF_W]};
    fold2   = clmulHalf(fold1[HALF_W-1:0], FOLD_HI)
            ^ {fold1[HALF_W-1:0], fold1[BLK_W-1:HALF_W]};
    product = fold2 ^ highPart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      keyReg <= '0;
      accReg <= '0;
    end else if (strobes.loadKey) begin
      keyReg <= keyIn;
      accReg <= '0;
    end else if (strobes.absorb) begin
      accReg <= product;
    end
  end

  assign accOut = accReg;
endmodule

// File: rtl/polyval_mac.sv
module polyval_mac
  import polyval_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         keyValid,
  input  logic [127:0] keyIn,
  input  logic         blkValid,
  input  logic         blkLast,
  input  logic [127:0] blkData,
  output logic [127:0] hashOut,
  output logic         hashDone
);
  ctrl_strobes_t strobes;

  polyval_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .keyValid (keyValid),
    .blkValid (blkValid),
    .blkLast  (blkLast),
    .strobes  (strobes),
    .doneReg  (hashDone)
  );

  polyval_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .keyIn   (keyIn),
    .blkData (blkData),
    .accOut  (hashOut)
  );
endmodule

// File: rtl/polyval_mac_chk.sv
module polyval_mac_chk (
  input logic         clk,
  input logic         rstN,
  input logic         keyValid,
  input logic         blkValid,
  input logic         blkLast,
  input logic [127:0] hashOut,
  input logic         hashDone
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (hashOut == '0 && !hashDone));

  p_key_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> (hashOut == '0 && !hashDone));

  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && blkLast && !keyValid) |=> hashDone);

  p_done_only_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!(blkValid && blkLast) || keyValid) |=> !hashDone);

  p_collision_no_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && blkValid) |=> (!hashDone && hashOut == '0));

  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!keyValid && !blkValid) |=> ($stable(hashOut) && !hashDone));
endmodule

bind polyval_mac polyval_mac_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .keyValid (keyValid),
  .blkValid (blkValid),
  .blkLast  (blkLast),
  .hashOut  (hashOut),
  .hashDone (hashDone)
);

// File: tb/test_polyval_mac.sv
module test_polyval_mac;
  logic         clk = 1'b0;
  logic         rstN;
  logic         keyValid;
  logic [127:0] keyIn;
  logic         blkValid;
  logic         blkLast;
  logic [127:0] blkData;
  logic [127:0] hashOut;
  logic         hashDone;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  polyval_mac i_polyval_mac (
    .clk(clk), .rstN(rstN), .keyValid(keyValid), .keyIn(keyIn),
    .blkValid(blkValid), .blkLast(blkLast), .blkData(blkData),
    .hashOut(hashOut), .hashDone(hashDone)
  );

  localparam logic [128:0] POLY = {1'b1, 128'h0} | (129'd1 << 127)
                                | (129'd1 << 126) | (129'd1 << 121) | 129'd1;

  // Bit-serial a*b*x^-128 mod POLY
  function automatic logic [127:0] refDot(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    logic [128:0] v;
    r = '0;
    for (int i = 127; i >= 0; i--) begin
      v = {r, 1'b0};
      if (v[128]) v = v ^ POLY;
      r = v[127:0];
      if (b[i]) r = r ^ a;
    end
    for (int k = 0; k < 128; k++) begin
      v = {1'b0, r};
      if (v[0]) v = v ^ POLY;
      r = v[128:1];
    end
    return r;
  endfunction

  function automatic logic [127:0] byteRev(input logic [127:0] s);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[8*i +: 8] = s[8*(15-i) +: 8];
    return o;
  endfunction

  function automatic logic [127:0] rand128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    keyValid = 1'b0; blkValid = 1'b0; blkLast = 1'b0;
  endtask

  task automatic loadKey(input logic [127:0] k);
    @(negedge clk);
    keyValid = 1'b1; keyIn = k; blkValid = 1'b0; blkLast = 1'b0;
    @(posedge clk); #1;
    keyValid = 1'b0;
  endtask

  task automatic sendBlock(input logic [127:0] x, input logic last);
    @(negedge clk);
    blkValid = 1'b1; blkData = x; blkLast = last; keyValid = 1'b0;
    @(posedge clk); #1;
    blkValid = 1'b0; blkLast = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] h, t, x, x1, x2, held;
    void'($urandom(32'd20245));
    rstN = 1'b0; keyValid = 1'b0; blkValid = 1'b0; blkLast = 1'b0;
    keyIn = '0; blkData = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset hash", hashOut, '0);
    check("R1 reset done", {127'd0, hashDone}, '0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", {hashOut[126:0], hashDone}, '0);

    // R3: published two-block POLYVAL vector
    h  = byteRev(128'h25629347589242761d31f826ba4b757b);
    x1 = byteRev(128'h4f4f95668c83dfb6401762bb2d01a262);
    x2 = byteRev(128'hd1a24ddd2721d006bbe45f20d3c9f362);
    loadKey(h);
    check("R2 key load clears", hashOut, '0);
    sendBlock(x1, 1'b0);
    check("R5 no done mid message", {127'd0, hashDone}, '0);
    sendBlock(x2, 1'b1);
    check("R3 known vector", hashOut, byteRev(128'hf7a3b47b846119fae5b7866cf5e5b77e));
    check("R5 done on last", {127'd0, hashDone}, 128'd1);
    held = hashOut;
    idle(); @(posedge clk); #1;
    check("R5 done one cycle", {127'd0, hashDone}, '0);
    check("R7 idle hold", hashOut, held);

    // R4: next message restarts from zero (same key)
    sendBlock(x1, 1'b1);
    check("R4 fresh after last", hashOut, refDot(x1, h));

    // Random messages with bit-serial reference
    for (int m = 0; m < 6; m++) begin
      int len;
      h = rand128();
      len = 1 + ($urandom % 5);
      loadKey(h);
      check("R2 key clears hash", hashOut, '0);
      t = '0;
      for (int b = 0; b < len; b++) begin
        x = rand128();
        t = refDot(x ^ t, h);
        sendBlock(x, b == len - 1);
        check("R3 random block", hashOut, t);
        check("R5 done flag", {127'd0, hashDone}, {127'd0, (b == len - 1)});
        if ($urandom % 2 == 1) begin
          idle(); @(posedge clk); #1;
          check("R7 idle gap", hashOut, t);
        end
      end
    end

    // Corner: zero key and all-ones blocks
    loadKey('0);
    sendBlock('1, 1'b1);
    check("R3 zero key", hashOut, '0);
    h = '1;
    loadKey(h);
    sendBlock('1, 1'b0);
    t = refDot('1, h);
    check("R3 ones", hashOut, t);

    // R6: key load and block in the same cycle
    @(negedge clk);
    keyValid = 1'b1; keyIn = h; blkValid = 1'b1; blkLast = 1'b1; blkData = '1;
    @(posedge clk); #1;
    keyValid = 1'b0; blkValid = 1'b0; blkLast = 1'b0;
    check("R6 collision hash zero", hashOut, '0);
    check("R6 collision no done", {127'd0, hashDone}, '0);
    x = rand128();
    sendBlock(x, 1'b1);
    check("R6 block dropped, fresh start", hashOut, refDot(x, h));

    // R2: key load mid message clears and restarts
    sendBlock(x, 1'b0);
    loadKey(x);
    check("R2 mid-message key", hashOut, '0);
    sendBlock(h, 1'b1);
    check("R4 fresh after key", hashOut, refDot(h, x));

    idle();
    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule